// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block holds the valid, dirty and tag state of two small direct-mapped caches, one for instructions and one for data, each with 16-byte lines. It carries out one maintenance command at a time. Each command names an action, a reach and a set of caches. The action either drops entries or first writes dirty data back and then drops them. The reach is either the one line that maps the given address, every line whose address lies in the same 4 KiB page as the given address, or the whole cache.

The block walks the chosen lines one per cycle. For each dirty data line met by a push, it raises a write-back request that carries the line address. It holds that request until an acknowledge arrives, and then clears the line. When the walk is finished it pulses done for one cycle and becomes ready again. A fill port lets the surrounding cache install lines, and a probe port reports whether an address hits and whether that line is dirty. Both ports exist so the state can be set up and observed.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, every entry of both caches is invalid, cmdReady is high, and done and wbReq are low.
- R2: An invalidate command (cmdOp=0) clears the valid and dirty state of every selected entry and never raises wbReq, even for dirty data lines.
- R3: A push command (cmdOp=1) raises wbReq for each selected valid dirty data line, with wbAddr equal to the line address (tag, index, four zero bits). wbReq and wbAddr are held until wbAck, and the line is cleared in the cycle wbAck is seen.
- R4: A push on a selected line that is valid but clean clears it without a write-back request.
- R5: Line reach (cmdScope=0) affects only the entry at index cmdAddr[7:4], and only when its stored tag equals cmdAddr[31:8]. An entry with a different tag is left untouched.
- R6: Page reach (cmdScope=1) affects exactly the valid lines whose page number (line address bits [31:12]) equals cmdAddr[31:12]. Lines in other pages keep their state.
- R7: Whole reach (cmdScope=2 or 3) affects every valid line of the selected caches, whatever cmdAddr holds.
- R8: cmdCaches bit 0 selects the data cache and bit 1 selects the instruction cache. An unselected cache is left untouched. cmdCaches=0 changes nothing but still ends with a done pulse.
- R9: A push never writes back from the instruction cache. Instruction lines are only invalidated.
- R10: With both caches selected, all data-cache write-backs come before any instruction-cache work, and done pulses exactly once after both.
- R11: From the cycle after a command is accepted until done has pulsed, cmdReady is low and any cmdValid is ignored. done lasts one cycle, and cmdReady is high in the cycle after it.
- R12: A fill (fillEn) makes the line at fillAddr valid with that tag in the cache picked by fillInstr. It is marked dirty only for the data cache with fillDirty set. probeHit and probeDirty report that state for probeAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle and accepting a command |
| cmdOp | input | 1 | 0 invalidate, 1 push then invalidate |
| cmdScope | input | 2 | 0 line, 1 page, 2 or 3 whole cache |
| cmdCaches | input | 2 | bit 0 data cache, bit 1 instruction cache |
| cmdAddr | input | ADDR_W | Byte address for line and page reach |
| done | output | 1 | One-cycle pulse at the end of a command |
| wbReq | output | 1 | Write-back request for a dirty data line |
| wbAddr | output | ADDR_W | Line address being written back |
| wbAck | input | 1 | Write-back accepted |
| fillEn | input | 1 | Install a line |
| fillInstr | input | 1 | Fill target: 1 instruction cache, 0 data cache |
| fillAddr | input | ADDR_W | Address of the line to install |
| fillDirty | input | 1 | Mark the installed data line dirty |
| probeInstr | input | 1 | Probe target: 1 instruction cache, 0 data cache |
| probeAddr | input | ADDR_W | Address to look up |
| probeHit | output | 1 | Probed line is valid with a matching tag |
| probeDirty | output | 1 | Probed line hits and is dirty |

## Verification
The bench sweeps every combination of action, reach encoding and cache selection. Each combination runs twice: once with an address that hits a stored line, and once with the same index but a tag that differs only in its low bit. The second case stays in the same page, so it separates line reach from page reach. Each command is preceded by a fill pattern that changes with the command, mixing three pages, clean and dirty lines, and absent entries. After every command, all 32 entries are probed against a model, which shows whether unselected caches, other pages and clean lines were left alone. The order of write-back addresses is compared with the model as well. A final run injects a whole-cache invalidate while a push is waiting on acknowledge, to show that busy-time commands have no effect.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [1:0] {
    REACH_LINE = 2'd0,
    REACH_PAGE = 2'd1,
    REACH_ALL  = 2'd2
  } reach_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } seqState_e;

  // Strobes from the sequencer control to the tag datapath
  typedef struct packed {
    logic latchAddr;  // capture the command address
    logic clearEnt;   // drop valid and dirty of the walked entry
    logic selInstr;   // walked entry belongs to the instruction cache
  } cmoStrobes_t;
endpackage

// File: rtl/cmo_datapath.sv
module cmo_datapath
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cmoStrobes_t               strobes,
  input  logic [$clog2(LINES)-1:0]  walkIdx,
  input  reach_e                    opReach,
  input  logic [ADDR_W-1:0]         cmdAddr,
  input  logic                      fillEn,
  input  logic                      fillInstr,
  input  logic [ADDR_W-1:0]         fillAddr,
  input  logic                      fillDirty,
  input  logic                      probeInstr,
  input  logic [ADDR_W-1:0]         probeAddr,
  output logic                      entValid,
  output logic                      entDirty,
  output logic                      entMatch,
  output logic [ADDR_W-1:0]         wbAddr,
  output logic                      probeHit,
  output logic                      probeDirty
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int PG_SH = $clog2(PAGE_BYTES) - OFF_W;

  logic [LINES-1:0] vArr [2];
  logic [LINES-1:0] dArr [2];
  logic [TAG_W-1:0] tArr [2][LINES];
  logic [ADDR_W-1:0] opAddr;

  logic [IDX_W-1:0] fIdx;
  logic [TAG_W-1:0] fTag;
  assign fIdx = fillAddr[OFF_W +: IDX_W];
  assign fTag = fillAddr[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        vArr[c] <= '0;
        dArr[c] <= '0;
      end
      opAddr <= '0;
    end else begin
      if (strobes.latchAddr) opAddr <= cmdAddr;
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < LINES; i++) begin
          if (fillEn && (fillInstr == (c == 1)) && (fIdx == IDX_W'(i))) begin
            vArr[c][i] <= 1'b1;
            dArr[c][i] <= fillDirty && (c == 0);
          end
          // a maintenance clear wins over a same-cycle fill
          if (strobes.clearEnt && (strobes.selInstr == (c == 1)) && (walkIdx == IDX_W'(i))) begin
            vArr[c][i] <= 1'b0;
            dArr[c][i] <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) tArr[fillInstr][fIdx] <= fTag;
  end

  // Walked entry and its match against the command
  logic [LN_W-1:0] entLine;
  logic [LN_W-1:0] cmdLine;
  assign entLine  = {tArr[strobes.selInstr][walkIdx], walkIdx};
  assign cmdLine  = opAddr[ADDR_W-1:OFF_W];
  assign entValid = vArr[strobes.selInstr][walkIdx];
  assign entDirty = dArr[strobes.selInstr][walkIdx];
  assign wbAddr   = {entLine, {OFF_W{1'b0}}};

  always_comb begin
    unique case (opReach)
      REACH_LINE: entMatch = (entLine == cmdLine);
      REACH_PAGE: entMatch = (entLine[LN_W-1:PG_SH] == cmdLine[LN_W-1:PG_SH]);
      default:    entMatch = 1'b1;
    endcase
  end

  // Lookup port
  logic [IDX_W-1:0] pIdx;
  assign pIdx       = probeAddr[OFF_W +: IDX_W];
  assign probeHit   = vArr[probeInstr][pIdx] && (tArr[probeInstr][pIdx] == probeAddr[ADDR_W-1 -: TAG_W]);
  assign probeDirty = probeHit && dArr[probeInstr][pIdx];
endmodule

// File: rtl/cmo_control.sv
module cmo_control
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  output logic                     cmdReady,
  input  logic                     cmdOp,
  input  logic [1:0]               cmdScope,
  input  logic [1:0]               cmdCaches,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic                     entValid,
  input  logic                     entDirty,
  input  logic                     entMatch,
  input  logic                     wbAck,
  output logic                     wbReq,
  output logic                     done,
  output cmoStrobes_t              strobes,
  output logic [$clog2(LINES)-1:0] walkIdx,
  output reach_e                   opReach
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);

  seqState_e        state;
  logic             opPush;
  logic             wantInstr;
  logic             curInstr;
  logic [IDX_W-1:0] startIdx;

  reach_e           cmdReach;
  logic [IDX_W-1:0] cmdStart;
  logic             hit, needWb, lastEnt, doStep;

  assign cmdReach = (cmdScope == 2'd0) ? REACH_LINE :
                    (cmdScope == 2'd1) ? REACH_PAGE : REACH_ALL;
  assign cmdStart = (cmdReach == REACH_LINE) ? cmdAddr[OFF_W +: IDX_W] : '0;

  assign cmdReady = (state == ST_IDLE);
  assign wbReq    = (state == ST_WB);
  assign done     = (state == ST_DONE);

  assign hit     = entValid && entMatch;
  assign needWb  = opPush && !curInstr && entDirty;
  assign lastEnt = (opReach == REACH_LINE) || (walkIdx == IDX_W'(LINES - 1));
  assign doStep  = ((state == ST_WALK) && !(hit && needWb)) || ((state == ST_WB) && wbAck);

  always_comb begin
    strobes.latchAddr = cmdReady && cmdValid;
    strobes.selInstr  = curInstr;
    strobes.clearEnt  = ((state == ST_WALK) && hit && !needWb) || ((state == ST_WB) && wbAck);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opPush    <= 1'b0;
      opReach   <= REACH_ALL;
      wantInstr <= 1'b0;
      curInstr  <= 1'b0;
      startIdx  <= '0;
      walkIdx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmdValid) begin
          opPush    <= cmdOp;
          opReach   <= cmdReach;
          wantInstr <= cmdCaches[1];
          curInstr  <= !cmdCaches[0];
          startIdx  <= cmdStart;
          walkIdx   <= cmdStart;
          state     <= (cmdCaches == 2'b00) ? ST_DONE : ST_WALK;
        end
        ST_WALK: if (hit && needWb) state <= ST_WB;
        ST_WB:   ;
        ST_DONE: state <= ST_IDLE;
      endcase
      if (doStep) begin
        if (!lastEnt) begin
          walkIdx <= walkIdx + 1'b1;
          state   <= ST_WALK;
        end else if (!curInstr && wantInstr) begin
          curInstr <= 1'b1;
          walkIdx  <= startIdx;
          state    <= ST_WALK;
        end else begin
          state <= ST_DONE;
        end
      end
    end
  end
endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq
  import cmo_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdOp,
  input  logic [1:0]        cmdScope,
  input  logic [1:0]        cmdCaches,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              done,
  output logic              wbReq,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbAck,
  input  logic              fillEn,
  input  logic              fillInstr,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              fillDirty,
  input  logic              probeInstr,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              probeHit,
  output logic              probeDirty
);
  localparam int IDX_W = $clog2(LINES);

  cmoStrobes_t      strobes;
  logic [IDX_W-1:0] walkIdx;
  reach_e           opReach;
  logic             entValid, entDirty, entMatch;

  cmo_control #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)) uCtl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdScope(cmdScope), .cmdCaches(cmdCaches), .cmdAddr(cmdAddr),
    .entValid(entValid), .entDirty(entDirty), .entMatch(entMatch), .wbAck(wbAck),
    .wbReq(wbReq), .done(done), .strobes(strobes), .walkIdx(walkIdx), .opReach(opReach)
  );

  cmo_datapath #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES),
                 .PAGE_BYTES(PAGE_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .walkIdx(walkIdx), .opReach(opReach),
    .cmdAddr(cmdAddr), .fillEn(fillEn), .fillInstr(fillInstr), .fillAddr(fillAddr),
    .fillDirty(fillDirty), .probeInstr(probeInstr), .probeAddr(probeAddr),
    .entValid(entValid), .entDirty(entDirty), .entMatch(entMatch), .wbAddr(wbAddr),
    .probeHit(probeHit), .probeDirty(probeDirty)
  );
endmodule

// File: rtl/cache_maint_seq_sva.sv
module cache_maint_seq_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              done,
  input logic              wbReq,
  input logic              wbAck,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              clearEnt,
  input logic              selInstr
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!wbReq && !done));

  p_wb_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbAddr)));

  p_wb_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && wbAck) |-> (clearEnt && !selInstr));

  p_wb_data_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> !selInstr);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && cmdReady));
endmodule

bind cache_maint_seq cache_maint_seq_sva #(.ADDR_W(ADDR_W)) uSva (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .done(done),
  .wbReq(wbReq), .wbAck(wbAck), .wbAddr(wbAddr),
  .clearEnt(strobes.clearEnt), .selInstr(strobes.selInstr)
);

// File: tb/test_cache_maint_seq.sv
`timescale 1ns/1ps
module test_cache_maint_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdOp = 1'b0;
  logic [1:0]  cmdScope = 2'd0, cmdCaches = 2'd0;
  logic [31:0] cmdAddr = '0;
  logic        cmdReady, done, wbReq;
  logic [31:0] wbAddr;
  logic        wbAck = 1'b0;
  logic        fillEn = 1'b0, fillInstr = 1'b0, fillDirty = 1'b0;
  logic [31:0] fillAddr = '0;
  logic        probeInstr = 1'b0;
  logic [31:0] probeAddr = '0;
  logic        probeHit, probeDirty;

  always #4 clk = ~clk;  // 125 MHz

  cache_maint_seq i_cache_maint_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdScope(cmdScope), .cmdCaches(cmdCaches), .cmdAddr(cmdAddr), .done(done),
    .wbReq(wbReq), .wbAddr(wbAddr), .wbAck(wbAck), .fillEn(fillEn), .fillInstr(fillInstr),
    .fillAddr(fillAddr), .fillDirty(fillDirty), .probeInstr(probeInstr),
    .probeAddr(probeAddr), .probeHit(probeHit), .probeDirty(probeDirty)
  );

  int nTests = 0, nFail = 0;
  bit          mV [2][16];
  bit          mD [2][16];
  logic [23:0] mT [2][16];
  logic [31:0] expWb [64];
  logic [31:0] gotWb [64];
  int expN = 0, gotN = 0, doneN = 0, wbWait = 0;
  bit lateWb = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Write-back responder and done counter
  initial begin
    forever begin
      @(negedge clk);
      if (done) doneN++;
      if (wbAck) wbAck = 1'b0;
      else if (wbReq) begin
        if (wbWait == 2) begin
          wbAck = 1'b1;
          if (gotN < 64) gotWb[gotN] = wbAddr;
          gotN++;
          wbWait = 0;
        end else wbWait++;
      end
    end
  end

  task automatic fillAll(input int seed);
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 16; i++) begin
        if ((i + seed) % 5 != 4) begin
          logic [23:0] tg;
          bit dy;
          tg = 24'h001000 + 24'(((i + seed) % 3) << 4) + 24'(i % 4) + 24'(c << 2);
          dy = ((i + seed) % 2) == 1;
          @(negedge clk);
          fillEn = 1'b1; fillInstr = (c == 1); fillDirty = dy;
          fillAddr = {tg, 4'(i), 4'h0};
          mV[c][i] = 1'b1; mT[c][i] = tg; mD[c][i] = dy && (c == 0);
        end
      end
    end
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  // R12: probe every entry against the model
  task automatic probeAll(input string req);
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 16; i++) begin
        probeInstr = (c == 1);
        probeAddr = {mT[c][i], 4'(i), 4'h0};
        #1;
        chk(probeHit == mV[c][i] && probeDirty == (mV[c][i] && mD[c][i]), req,
            $sformatf("probe cache %0d line %0d {hit,dirty}", c, i),
            {30'd0, probeHit, probeDirty}, {30'd0, mV[c][i], mV[c][i] && mD[c][i]});
      end
    end
  endtask

  // Model of one command: data cache first (R10), instr never written back (R9)
  task automatic modelCmd(input bit op, input logic [1:0] sc, input logic [1:0] ca,
                          input logic [31:0] ad);
    expN = 0;
    for (int k = 0; k < 2; k++) begin
      if (ca[k]) begin
        for (int i = 0; i < 16; i++) begin
          logic [27:0] ln;
          bit m;
          ln = {mT[k][i], 4'(i)};
          if (sc == 2'd0) m = (ln == ad[31:4]);                 // R5
          else if (sc == 2'd1) m = (ln[27:8] == ad[31:12]);     // R6
          else m = 1'b1;                                        // R7
          if (mV[k][i] && m) begin
            if (op && k == 0 && mD[k][i]) begin                 // R3, R4
              expWb[expN] = {ln, 4'h0};
              expN++;
            end
            mV[k][i] = 1'b0; mD[k][i] = 1'b0;                   // R2
          end
        end
      end
    end
  endtask

  task automatic runCmd(input bit op, input logic [1:0] sc, input logic [1:0] ca,
                        input logic [31:0] ad, input bit poke);
    int cnt;
    modelCmd(op, sc, ca, ad);
    gotN = 0; doneN = 0; wbWait = 0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdScope = sc; cmdCaches = ca; cmdAddr = ad;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(cmdReady == 1'b0, "R11", "cmdReady after accept", {31'd0, cmdReady}, 32'd0);
    if (poke) begin
      repeat (2) @(negedge clk);
      cmdValid = 1'b1; cmdOp = 1'b0; cmdScope = 2'd2; cmdCaches = 2'd3;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    cnt = 0;
    while (doneN == 0 && cnt < 3000) begin
      @(negedge clk);
      cnt++;
    end
    @(negedge clk);
    #1;
    chk(doneN == 1, "R11", "done pulses per command", 32'(doneN), 32'd1);
    chk(cmdReady == 1'b1 && done == 1'b0, "R11", "ready after done",
        {30'd0, cmdReady, done}, 32'd2);
    chk(gotN == expN, (ca == 2'd3) ? "R10" : (op ? "R3" : "R2"), "write-back count",
        32'(gotN), 32'(expN));
    for (int j = 0; j < expN && j < gotN; j++)
      chk(gotWb[j] == expWb[j], "R3", $sformatf("write-back %0d address", j),
          gotWb[j], expWb[j]);
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 16; i++) begin
        mV[c][i] = 1'b0; mD[c][i] = 1'b0; mT[c][i] = 24'h001000;
      end
    repeat (3) @(negedge clk);
    #1;
    chk(cmdReady == 1'b1 && done == 1'b0 && wbReq == 1'b0, "R1", "outputs in reset",
        {29'd0, cmdReady, done, wbReq}, 32'd4);
    rstN = 1'b1;
    @(negedge clk);
    probeAll("R1");

    // Sweep: action x reach encoding x cache selection x hit/miss address
    for (int op = 0; op < 2; op++)
      for (int sc = 0; sc < 4; sc++)
        for (int ca = 0; ca < 4; ca++)
          for (int v = 0; v < 2; v++) begin
            logic [31:0] ad;
            int tc;
            fillAll(op * 32 + sc * 8 + ca * 2 + v);
            probeAll("R12");
            tc = (ca == 2) ? 1 : 0;
            ad = {mT[tc][5] ^ 24'(v), 4'd5, 4'h0};  // v=1: same page, other line tag
            runCmd(op[0], 2'(sc), 2'(ca), ad, 1'b0);
            probeAll(ca == 0 ? "R8" : (sc == 0 ? "R5" : (sc == 1 ? "R6" : "R7")));
          end

    // R11: a whole-cache invalidate offered during a push is ignored
    fillAll(3);
    runCmd(1'b1, 2'd2, 2'd1, 32'h0, 1'b1);
    probeAll("R11");

    // R9: push on the instruction cache alone writes nothing back
    fillAll(1);
    runCmd(1'b1, 2'd2, 2'd2, 32'h0, 1'b0);
    probeAll("R9");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule